// File: doc/BRIEF.md
# Translation Lookaside Cache with Invalidation and Access Check

This block is a small fully associative cache of page translations that sits between an address requester and a page table walker. A request carries a virtual page number, a read/write flag and a user/supervisor flag. When the page is cached, the block answers in the same cycle with the physical page number, the cache-inhibit attribute and a protection fault verdict. When the page is not cached, the block sends the page number to the walker, waits for the returned table entry and installs it. The requester keeps its request asserted until the hit appears.

Two controls remove entries. The first is a pulse that signals a write of the table base register, and it clears the whole cache. The second is a page invalidate that removes only the entry for one virtual page. If either control arrives while a walk is outstanding, the entry that the walk returns is thrown away, so a translation that may be stale is never installed.

Top module: `xlat_cache`

## Requirements
- R1: A cycle with `base_wr` high clears every entry. From the next cycle on, every lookup misses until a new fill. The pulse also sends the replacement pointer back to entry 0.
- R2: A cycle with `pg_inv` high clears only the entry whose tag equals `pg_inv_vpn`. All other entries keep answering hits.
- R3: A lookup that hits raises `rsp_hit` in the same cycle. `rsp_ppn` comes from bits 31:12 of the installed entry, and `rsp_nocache` comes from bit 6.
- R4: On a miss, `walk_req` goes high on the next cycle with `walk_vpn` equal to the requested page. Both hold until the cycle in which `walk_done` is high. The returned entry is installed at that edge, and the held request hits on the following cycle.
- R5: For a supervisor access (`req_user`=0), a read never faults. A write faults only when entry bit 2 (user access allowed) and entry bit 1 (writable) are both 0. When bit 2 is 1, a supervisor write is allowed even if bit 1 is 0.
- R6: For a user access (`req_user`=1), a fault is reported when entry bit 2 is 0, or when the access is a write (`req_write`=1) and entry bit 1 is 0.
- R7: Fills go to the 8 entries in round-robin order, whatever the holes are. After a `base_wr` pulse, the ninth fill overwrites the first page installed and leaves the other eight cached.
- R8: If `base_wr` or `pg_inv` is high in any cycle from the first cycle of `walk_req` up to and including the `walk_done` cycle, the returned entry is not installed.
- R9: After reset, no entry is valid, `walk_req` is low and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request; held until `rsp_hit` |
| req_vpn | input | 20 | Virtual page number of the request |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| rsp_hit | output | 1 | Request hits a valid entry this cycle |
| rsp_ppn | output | 20 | Physical page number of the hit |
| rsp_nocache | output | 1 | Cache-inhibit attribute of the hit |
| rsp_fault | output | 1 | Protection fault for the hit access |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | 20 | Page number sent to the walker |
| walk_done | input | 1 | Walker returns an entry this cycle |
| walk_pte | input | 32 | Returned entry: 31:12 page, 6 no-cache, 2 user, 1 writable |
| base_wr | input | 1 | Table base register written: flush all |
| pg_inv | input | 1 | Invalidate one page |
| pg_inv_vpn | input | 20 | Page to invalidate |

## Verification
The assertions assume that the requester keeps `req_valid` and `req_vpn` stable from a miss until the hit. They also assume that `walk_done` is pulsed only while `walk_req` is high. Under those rules no page can be installed twice, so at most one tag matches. Every bench task holds the request through the whole walk and pulses `walk_done` once, only after it has seen `walk_req`. Pure probes that must not start a walk drive the request and drop it again within the low half of the clock, so no edge sees them.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // Entry bit positions decoded by the access check and output mux
   localparam int unsigned OFS_W   = 12;
   localparam int unsigned BIT_WR  = 1;
   localparam int unsigned BIT_USR = 2;
   localparam int unsigned BIT_NC  = 6;

   typedef struct packed {
      logic nocache;
      logic user_ok;
      logic writable;
   } pg_attr_t;
endpackage

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
   parameter int unsigned N = 8,
   parameter int unsigned W = 20
) (
   input  logic [N-1:0]        vld,
   input  logic [N-1:0][W-1:0] tags,
   input  logic [W-1:0]        key,
   output logic [N-1:0]        hit
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = vld[i] && (tags[i] == key);
   end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
   import xlat_pkg::*;
(
   input  pg_attr_t attr,
   input  logic     user,
   input  logic     write,
   output logic     fault
);
   always_comb begin
      if (user) fault = !attr.user_ok || (write && !attr.writable);
      else      fault = write && !attr.user_ok && !attr.writable;
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          advance,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (clear)   idx <= '0;
      else if (advance) idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 20,
   localparam int unsigned PTE_W  = PPN_W + OFS_W,
   localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic             req_write,
   input  logic             req_user,
   output logic             rsp_hit,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_nocache,
   output logic             rsp_fault,
   output logic             walk_req,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             walk_done,
   input  logic [PTE_W-1:0] walk_pte,
   input  logic             base_wr,
   input  logic             pg_inv,
   input  logic [VPN_W-1:0] pg_inv_vpn
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("xlat_cache: page number widths must be positive");
   end

   logic [ENTRIES-1:0]             vld_q;
   logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
   pg_attr_t [ENTRIES-1:0]         attr_q;

   logic [ENTRIES-1:0] hit_vec, inv_vec;
   logic               hit_any;
   logic [PPN_W-1:0]   hit_ppn;
   pg_attr_t           hit_attr;
   logic               pend_q, drop_q;
   logic [VPN_W-1:0]   vpn_q;
   logic [IW-1:0]      vict;
   logic               start, kill, fill_ok;
   pg_attr_t           new_attr;

   xlat_tag_match #(.N(ENTRIES), .W(VPN_W)) u_look (
      .vld(vld_q), .tags(tag_q), .key(req_vpn), .hit(hit_vec));

   xlat_tag_match #(.N(ENTRIES), .W(VPN_W)) u_inv (
      .vld(vld_q), .tags(tag_q), .key(pg_inv_vpn), .hit(inv_vec));

   always_comb begin
      hit_ppn  = '0;
      hit_attr = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            hit_ppn  = hit_ppn | ppn_q[i];
            hit_attr = hit_attr | attr_q[i];
         end
      end
   end

   assign hit_any     = |hit_vec;
   assign rsp_hit     = req_valid && hit_any;
   assign rsp_ppn     = hit_ppn;
   assign rsp_nocache = hit_attr.nocache;

   xlat_perm u_perm (
      .attr(hit_attr), .user(req_user), .write(req_write), .fault(rsp_fault));

   assign start    = req_valid && !hit_any && !pend_q;
   assign kill     = base_wr || pg_inv;
   assign fill_ok  = pend_q && walk_done && !drop_q && !kill;
   assign walk_req = pend_q;
   assign walk_vpn = vpn_q;

   assign new_attr.nocache  = walk_pte[BIT_NC];
   assign new_attr.user_ok  = walk_pte[BIT_USR];
   assign new_attr.writable = walk_pte[BIT_WR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         drop_q <= 1'b0;
         vpn_q  <= '0;
      end else begin
         if (start) begin
            pend_q <= 1'b1;
            drop_q <= 1'b0;
            vpn_q  <= req_vpn;
         end else if (pend_q && walk_done) begin
            pend_q <= 1'b0;
            drop_q <= 1'b0;
         end else if (pend_q && kill) begin
            drop_q <= 1'b1;
         end
      end
   end

   xlat_victim #(.N(ENTRIES)) u_vict (
      .clk(clk), .rst_n(rst_n), .clear(base_wr), .advance(fill_ok), .idx(vict));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         tag_q  <= '0;
         ppn_q  <= '0;
         attr_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (base_wr) begin
               vld_q[i] <= 1'b0;
            end else if (pg_inv && inv_vec[i]) begin
               vld_q[i] <= 1'b0;
            end else if (fill_ok && (vict == IW'(i))) begin
               vld_q[i]  <= 1'b1;
               tag_q[i]  <= vpn_q;
               ppn_q[i]  <= walk_pte[PTE_W-1:OFS_W];
               attr_q[i] <= new_attr;
            end
         end
      end
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int unsigned N  = 8,
   parameter int unsigned VW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [VW-1:0] req_vpn,
   input logic          req_write,
   input logic          req_user,
   input logic          rsp_hit,
   input logic          rsp_fault,
   input logic          walk_req,
   input logic [VW-1:0] walk_vpn,
   input logic          walk_done,
   input logic          base_wr,
   input logic          pg_inv,
   input logic [VW-1:0] pg_inv_vpn,
   input logic [N-1:0]  hit_vec
);
   a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> !rsp_hit);

   a_r2_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
      pg_inv |=> !(rsp_hit && req_vpn == $past(pg_inv_vpn)));

   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r4_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req && !walk_done |=> walk_req && $stable(walk_vpn));

   a_r4_no_hit_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !rsp_hit);

   a_r5_sup_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit && !req_user && !req_write |-> !rsp_fault);
endmodule

bind xlat_cache xlat_cache_chk #(.N(ENTRIES), .VW(VPN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
   .req_write(req_write), .req_user(req_user), .rsp_hit(rsp_hit),
   .rsp_fault(rsp_fault), .walk_req(walk_req), .walk_vpn(walk_vpn),
   .walk_done(walk_done), .base_wr(base_wr), .pg_inv(pg_inv),
   .pg_inv_vpn(pg_inv_vpn), .hit_vec(hit_vec));

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_vpn = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_hit, rsp_nocache, rsp_fault, walk_req;
   logic [19:0] rsp_ppn, walk_vpn;
   logic        walk_done = 1'b0;
   logic [31:0] walk_pte = '0;
   logic        base_wr = 1'b0;
   logic        pg_inv = 1'b0;
   logic [19:0] pg_inv_vpn = '0;

   int vec_cnt = 0;
   int err_cnt = 0;
   bit done = 0;

   always #4 clk = ~clk;

   xlat_cache u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      vec_cnt++;
      if (!ok) begin
         err_cnt++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input bit nc,
                                         input bit usr, input bit wr);
      return {ppn, 5'b0, nc, 3'b0, usr, wr, 1'b1};
   endfunction

   function automatic bit exp_fault(input bit usr, input bit wr, input bit user,
                                    input bit write);
      if (user) return !usr || (write && !wr);
      return write && !usr && !wr;
   endfunction

   // Lookup seen by no clock edge
   task automatic probe(input logic [19:0] vpn, input bit write, input bit user);
      @(negedge clk);
      req_vpn = vpn; req_write = write; req_user = user; req_valid = 1'b1;
      #1;
      req_valid = 1'b0;
   endtask

   // Full access with walker service; leaves outputs of the hit sampled
   task automatic fill(input logic [19:0] vpn, input logic [31:0] pte);
      @(negedge clk);
      req_vpn = vpn; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
      #1;
      chk(!rsp_hit, "R4 first lookup misses", 32'(rsp_hit), 0);
      @(negedge clk);
      chk(walk_req && walk_vpn == vpn, "R4 walk request", 32'(walk_vpn), 32'(vpn));
      walk_done = 1'b1; walk_pte = pte;
      @(negedge clk);
      walk_done = 1'b0;
      #1;
      chk(rsp_hit, "R4 hit after fill", 32'(rsp_hit), 1);
      req_valid = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk); base_wr = 1'b1;
      @(negedge clk); base_wr = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(!walk_req, "R9 walk idle after reset", 32'(walk_req), 0);
      probe(20'h0, 0, 0);
      chk(!rsp_hit, "R9 empty after reset", 32'(rsp_hit), 0);
      probe(20'h12345, 1, 1);
      chk(!rsp_hit, "R9 empty after reset", 32'(rsp_hit), 0);
   endtask

   task automatic t_hit_data();
      fill(20'h12345, mk_pte(20'hABCDE, 1, 1, 1));
      probe(20'h12345, 0, 0);
      chk(rsp_hit && rsp_ppn == 20'hABCDE, "R3 ppn", 32'(rsp_ppn), 32'hABCDE);
      chk(rsp_nocache, "R3 nocache set", 32'(rsp_nocache), 1);
      fill(20'h00777, mk_pte(20'h54321, 0, 1, 1));
      probe(20'h00777, 0, 1);
      chk(rsp_ppn == 20'h54321 && !rsp_nocache, "R3 second page",
          {rsp_ppn, 11'b0, rsp_nocache}, {20'h54321, 12'b0});
   endtask

   task automatic t_protect();
      flush();
      for (int p = 0; p < 4; p++) begin
         fill(20'h200 + 20'(p), mk_pte(20'h300 + 20'(p), 0, p[1], p[0]));
      end
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 4; m++) begin
            bit e;
            e = exp_fault(p[1], p[0], m[1], m[0]);
            probe(20'h200 + 20'(p), m[0], m[1]);
            if (m[1]) chk(rsp_hit && rsp_fault == e, "R6 user access check",
                          32'(rsp_fault), 32'(e));
            else      chk(rsp_hit && rsp_fault == e, "R5 supervisor access check",
                          32'(rsp_fault), 32'(e));
         end
      end
   endtask

   task automatic t_page_inv();
      @(negedge clk); pg_inv = 1'b1; pg_inv_vpn = 20'h202;
      @(negedge clk); pg_inv = 1'b0;
      probe(20'h202, 0, 0);
      chk(!rsp_hit, "R2 target removed", 32'(rsp_hit), 0);
      for (int p = 0; p < 4; p++) begin
         if (p != 2) begin
            probe(20'h200 + 20'(p), 0, 0);
            chk(rsp_hit && rsp_ppn == 20'h300 + 20'(p), "R2 others kept",
                32'(rsp_ppn), 32'h300 + p);
         end
      end
   endtask

   task automatic t_flush();
      flush();
      for (int p = 0; p < 4; p++) begin
         probe(20'h200 + 20'(p), 0, 0);
         chk(!rsp_hit, "R1 flushed", 32'(rsp_hit), 0);
      end
   endtask

   task automatic t_round_robin();
      flush();
      for (int i = 0; i < 9; i++) fill(20'h400 + 20'(i), mk_pte(20'h500 + 20'(i), 0, 1, 1));
      probe(20'h400, 0, 0);
      chk(!rsp_hit, "R7 oldest evicted", 32'(rsp_hit), 0);
      for (int i = 1; i < 9; i++) begin
         probe(20'h400 + 20'(i), 0, 0);
         chk(rsp_hit && rsp_ppn == 20'h500 + 20'(i), "R7 others kept",
             32'(rsp_ppn), 32'h500 + i);
      end
   endtask

   // mode 0: flush mid-walk, 1: page invalidate on the return cycle
   task automatic t_discard(input int mode);
      @(negedge clk);
      req_vpn = 20'h777; req_write = 0; req_user = 0; req_valid = 1'b1;
      @(negedge clk);
      chk(walk_req, "R8 walk started", 32'(walk_req), 1);
      if (mode == 0) begin
         base_wr = 1'b1;
         @(negedge clk);
         base_wr = 1'b0;
      end else begin
         pg_inv = 1'b1; pg_inv_vpn = 20'h999;
      end
      walk_done = 1'b1; walk_pte = mk_pte(20'h888, 0, 1, 1);
      @(negedge clk);
      walk_done = 1'b0; pg_inv = 1'b0;
      #1;
      chk(!rsp_hit, "R8 fill discarded", 32'(rsp_hit), 0);
      req_valid = 1'b0;
      @(negedge clk);
      probe(20'h777, 0, 0);
      chk(!rsp_hit && !walk_req, "R8 no entry installed",
          {rsp_hit, walk_req}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_data();
      t_protect();
      t_page_inv();
      t_flush();
      t_round_robin();
      t_discard(0);
      t_discard(1);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         chk(0, "watchdog expired", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end
endmodule